// File: doc/BRIEF.md
# LCD Alternating-Drive Polarity Generator

This block produces the polarity signal that makes an LCD panel's drive voltage alternate. Without it the liquid crystal would see a DC bias. The output inverts either once per frame or once every N line pulses. A single 8-bit write-only period register selects which. The block sits behind the display timing generator. Each time a line is latched, it receives a one-cycle line strobe. Each time a frame begins, it receives a one-cycle frame strobe. All strobes are in the block's own clock domain.

A period value of zero selects frame-rate inversion. Any value N from 1 to 255 selects inversion after every N line strobes, counted without regard to frame boundaries. Software writes the period through a small address/data write port, and the block decodes one address for it. A write clears the line count, so a new period always starts from a clean count.

Top module: `lcd_acdrive_toggle`

## Requirements
- R1: After reset, the output `acdrive_m` is 0, the line count is 0 and the period register holds 0x00, which means frame mode.
- R2: A write with `cfg_wr_en` high and `cfg_addr` equal to 5'b01110 loads `cfg_wdata` into the period register. A write to any other address changes neither the period nor the output.
- R3: When the period is 0x00, `acdrive_m` inverts in the cycle after each `frame_strobe`, and `line_strobe` has no effect.
- R4: When the period is N (1 to 255), `acdrive_m` inverts in the cycle after every N-th `line_strobe`. For example, 0x01 inverts on every line, 0x02 on every second line and 0xFF on every 255th line.
- R5: When the period is nonzero, `frame_strobe` neither inverts the output nor resets the line count.
- R6: A period write clears the line count. After a write of N, the first inversion follows the N-th line strobe after the write cycle.
- R7: In a cycle that writes the period register, any line or frame strobe is discarded: it is not counted and causes no inversion.
- R8: `acdrive_m` changes only in the cycle that follows a strobe that triggers an inversion. In every other cycle it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_wr_en | input | 1 | Register write enable |
| cfg_addr | input | 5 | Register write address |
| cfg_wdata | input | 8 | Register write data |
| line_strobe | input | 1 | One-cycle pulse per display line |
| frame_strobe | input | 1 | One-cycle pulse per frame start |
| acdrive_m | output | 1 | Alternating-drive polarity output |

## Verification
The assertions assume that each strobe is a single-cycle pulse synchronous to `clk`. They also assume that the period register changes only through the decoded write, so the line count always stays below a nonzero period. The bench drives every strobe and write for exactly one clock between falling edges, and it asserts a strobe together with a write only in the case that tests discarding. For every period from 1 to 255 it issues twice N line strobes and predicts the output from the strobe index divided by N.

// File: rtl/acdrv_pkg.sv
package acdrv_pkg;

  localparam int unsigned ACDRV_ADDR_W = 5;
  localparam int unsigned ACDRV_DATA_W = 8;
  localparam logic [ACDRV_ADDR_W-1:0] ACDRV_PERIOD_ADDR = 5'b01110;

  typedef enum logic {
    MODE_FRAME = 1'b0,
    MODE_LINE  = 1'b1
  } acdrv_mode_e;

endpackage

// File: rtl/acdrv_rst_sync.sv
module acdrv_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/acdrv_cfg_reg.sv
module acdrv_cfg_reg
  import acdrv_pkg::*;
#(
  parameter int unsigned ADDR_W = ACDRV_ADDR_W,
  parameter int unsigned DATA_W = ACDRV_DATA_W,
  parameter logic [ADDR_W-1:0] PERIOD_ADDR = ACDRV_PERIOD_ADDR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              wr_hit,
  output logic [DATA_W-1:0] period_q,
  output acdrv_mode_e       mode
);

  logic [DATA_W-1:0] period_d;
  logic              period_en;

  // Address decode for the single period register
  always_comb begin
    wr_hit    = wr_en && (addr == PERIOD_ADDR);
    period_en = wr_hit;
    period_d  = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
    end else if (period_en) begin
      period_q <= period_d;
    end
  end

  // Zero period selects frame-rate inversion
  always_comb begin
    mode = (period_q == '0) ? MODE_FRAME : MODE_LINE;
  end

endmodule

// File: rtl/acdrv_line_cnt.sv
module acdrv_line_cnt
  import acdrv_pkg::*;
#(
  parameter int unsigned CNT_W = ACDRV_DATA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  acdrv_mode_e      mode,
  input  logic [CNT_W-1:0] period,
  input  logic             line_strobe,
  input  logic             clear,
  output logic [CNT_W-1:0] cnt_q,
  output logic             terminal
);

  logic [CNT_W:0]   cnt_inc;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             count_now;

  always_comb begin
    count_now = line_strobe && (mode == MODE_LINE) && !clear;
    cnt_inc   = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
    terminal  = count_now && (cnt_inc == {1'b0, period});
    cnt_en    = clear || count_now;
    if (clear || terminal) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_inc[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/acdrv_toggle.sv
module acdrv_toggle
  import acdrv_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  acdrv_mode_e mode,
  input  logic        frame_strobe,
  input  logic        line_terminal,
  input  logic        block,
  output logic        m_q
);

  logic flip;
  logic m_d;

  always_comb begin
    unique case (mode)
      MODE_FRAME: flip = frame_strobe && !block;
      MODE_LINE:  flip = line_terminal && !block;
      default:    flip = 1'b0;
    endcase
    m_d = ~m_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q <= 1'b0;
    end else if (flip) begin
      m_q <= m_d;
    end
  end

endmodule

// File: rtl/lcd_acdrive_toggle.sv
module lcd_acdrive_toggle
  import acdrv_pkg::*;
#(
  parameter int unsigned ADDR_W = ACDRV_ADDR_W,
  parameter int unsigned DATA_W = ACDRV_DATA_W,
  parameter logic [ADDR_W-1:0] PERIOD_ADDR = ACDRV_PERIOD_ADDR,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              line_strobe,
  input  logic              frame_strobe,
  output logic              acdrive_m
);

  logic              srst_n;
  logic              wr_hit;
  logic [DATA_W-1:0] period_q;
  acdrv_mode_e       mode;
  logic [DATA_W-1:0] cnt_q;
  logic              line_terminal;

  acdrv_rst_sync #(
    .STAGES (RST_STAGES)
  ) i_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  acdrv_cfg_reg #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .PERIOD_ADDR (PERIOD_ADDR)
  ) i_cfg_reg (
    .clk      (clk),
    .rst_n    (srst_n),
    .wr_en    (cfg_wr_en),
    .addr     (cfg_addr),
    .wdata    (cfg_wdata),
    .wr_hit   (wr_hit),
    .period_q (period_q),
    .mode     (mode)
  );

  acdrv_line_cnt #(
    .CNT_W (DATA_W)
  ) i_line_cnt (
    .clk         (clk),
    .rst_n       (srst_n),
    .mode        (mode),
    .period      (period_q),
    .line_strobe (line_strobe),
    .clear       (wr_hit),
    .cnt_q       (cnt_q),
    .terminal    (line_terminal)
  );

  acdrv_toggle i_toggle (
    .clk           (clk),
    .rst_n         (srst_n),
    .mode          (mode),
    .frame_strobe  (frame_strobe),
    .line_terminal (line_terminal),
    .block         (wr_hit),
    .m_q           (acdrive_m)
  );

endmodule

// File: rtl/acdrv_checker.sv
module acdrv_checker #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              srst_n,
  input logic              wr_hit,
  input logic [DATA_W-1:0] period_q,
  input logic [DATA_W-1:0] cnt_q,
  input logic              line_strobe,
  input logic              frame_strobe,
  input logic              m
);

  AST_RESET_STATE: assert property (@(posedge clk)
    $rose(srst_n) |-> (!m && cnt_q == '0 && period_q == '0)); // R1

  AST_WRITE_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!srst_n)
    wr_hit |=> (cnt_q == '0)); // R6

  AST_FRAME_INVERT: assert property (@(posedge clk) disable iff (!srst_n)
    (period_q == '0 && frame_strobe && !wr_hit) |=> (m != $past(m))); // R3

  AST_FRAME_MODE_COUNT_IDLE: assert property (@(posedge clk) disable iff (!srst_n)
    (period_q == '0) |-> (cnt_q == '0)); // R3

  AST_COUNT_BELOW_PERIOD: assert property (@(posedge clk) disable iff (!srst_n)
    (period_q != '0) |-> (cnt_q < period_q)); // R4

  AST_LINE_INVERT: assert property (@(posedge clk) disable iff (!srst_n)
    (period_q != '0 && line_strobe && !wr_hit && cnt_q == period_q - 1'b1)
    |=> (m != $past(m))); // R4

  AST_LINE_MODE_FRAME_IGNORED: assert property (@(posedge clk) disable iff (!srst_n)
    (period_q != '0 && frame_strobe && !line_strobe && !wr_hit) |=> $stable(m)); // R5

  AST_WRITE_DISCARDS_STROBE: assert property (@(posedge clk) disable iff (!srst_n)
    wr_hit |=> $stable(m)); // R7

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!srst_n)
    (!line_strobe && !frame_strobe) |=> $stable(m)); // R8

endmodule

bind lcd_acdrive_toggle acdrv_checker #(
  .DATA_W (DATA_W)
) i_acdrv_checker (
  .clk          (clk),
  .srst_n       (srst_n),
  .wr_hit       (wr_hit),
  .period_q     (period_q),
  .cnt_q        (cnt_q),
  .line_strobe  (line_strobe),
  .frame_strobe (frame_strobe),
  .m            (acdrive_m)
);

// File: tb/test_lcd_acdrive_toggle.sv
`timescale 1ns/1ps
module test_lcd_acdrive_toggle;

  localparam logic [4:0] REG_ADDR = 5'b01110;
  localparam int WATCHDOG = 190000;

  logic       clk;
  logic       rst_n;
  logic       cfg_wr_en;
  logic [4:0] cfg_addr;
  logic [7:0] cfg_wdata;
  logic       line_strobe;
  logic       frame_strobe;
  logic       acdrive_m;

  int tests;
  int fails;
  int cycles;

  lcd_acdrive_toggle i_lcd_acdrive_toggle (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_wr_en    (cfg_wr_en),
    .cfg_addr     (cfg_addr),
    .cfg_wdata    (cfg_wdata),
    .line_strobe  (line_strobe),
    .frame_strobe (frame_strobe),
    .acdrive_m    (acdrive_m)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles == WATCHDOG) begin
      fails++;
      tests++;
      $display("FAIL R8 watchdog: cycles=%0d expected below %0d", cycles, WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: acdrive_m=%0b expected %0b", req, act, exp);
    end
  endtask

  // One clock with the given inputs, then sample after the edge
  task automatic drive(input logic wr, input logic [4:0] a, input logic [7:0] d,
                       input logic ln, input logic fr);
    @(negedge clk);
    cfg_wr_en    = wr;
    cfg_addr     = a;
    cfg_wdata    = d;
    line_strobe  = ln;
    frame_strobe = fr;
    @(negedge clk);
    cfg_wr_en    = 1'b0;
    line_strobe  = 1'b0;
    frame_strobe = 1'b0;
  endtask

  task automatic write_period(input logic [7:0] d);
    drive(1'b1, REG_ADDR, d, 1'b0, 1'b0);
  endtask

  task automatic line_pulse();
    drive(1'b0, 5'd0, 8'd0, 1'b1, 1'b0);
  endtask

  task automatic frame_pulse();
    drive(1'b0, 5'd0, 8'd0, 1'b0, 1'b1);
  endtask

  initial begin
    logic m0;
    tests = 0;
    fails = 0;
    cycles = 0;
    rst_n = 1'b0;
    cfg_wr_en = 1'b0;
    cfg_addr = '0;
    cfg_wdata = '0;
    line_strobe = 1'b0;
    frame_strobe = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state, period 0 means line strobes do nothing
    check("R1 reset value", acdrive_m, 1'b0);
    for (int i = 0; i < 5; i++) line_pulse();
    check("R1 reset period is frame mode", acdrive_m, 1'b0);

    // R3: frame mode inverts on each frame strobe
    for (int i = 1; i <= 4; i++) begin
      frame_pulse();
      check("R3 frame inversion", acdrive_m, logic'(i % 2));
      line_pulse();
      check("R3 line ignored in frame mode", acdrive_m, logic'(i % 2));
    end

    // R8: idle cycles hold the output
    m0 = acdrive_m;
    repeat (7) @(negedge clk);
    check("R8 idle hold", acdrive_m, m0);

    // R2: write to another address is ignored (still frame mode)
    drive(1'b1, 5'b01111, 8'd1, 1'b0, 1'b0);
    line_pulse();
    check("R2 wrong address ignored", acdrive_m, m0);
    frame_pulse();
    check("R2 still frame mode", acdrive_m, ~m0);

    // R4: sweep every nonzero period
    for (int n = 1; n <= 255; n++) begin
      write_period(n[7:0]);
      m0 = acdrive_m;
      for (int k = 1; k <= 2 * n; k++) begin
        line_pulse();
        check("R4 line period sweep", acdrive_m, m0 ^ logic'((k / n) % 2));
      end
    end

    // R5: frame strobes in line mode neither invert nor reset the count
    write_period(8'd3);
    m0 = acdrive_m;
    line_pulse();
    frame_pulse();
    check("R5 frame ignored in line mode", acdrive_m, m0);
    line_pulse();
    frame_pulse();
    check("R5 frame ignored in line mode", acdrive_m, m0);
    line_pulse();
    check("R5 count kept across frame", acdrive_m, ~m0);

    // R6: rewrite clears the count
    write_period(8'd4);
    m0 = acdrive_m;
    line_pulse();
    line_pulse();
    write_period(8'd4);
    for (int k = 1; k <= 3; k++) begin
      line_pulse();
      check("R6 count cleared by write", acdrive_m, m0);
    end
    line_pulse();
    check("R6 inversion after N lines from write", acdrive_m, ~m0);

    // R7: strobe in the write cycle is discarded
    write_period(8'd1);
    m0 = acdrive_m;
    drive(1'b1, REG_ADDR, 8'd1, 1'b1, 1'b0);
    check("R7 line strobe discarded in write cycle", acdrive_m, m0);
    line_pulse();
    check("R7 next line counts", acdrive_m, ~m0);
    m0 = acdrive_m;
    drive(1'b1, REG_ADDR, 8'd0, 1'b0, 1'b1);
    check("R7 frame strobe discarded in write cycle", acdrive_m, m0);
    frame_pulse();
    check("R7 next frame inverts", acdrive_m, ~m0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule